// File: doc/BRIEF.md
# Vector Compare-to-Predicate-Mask Unit

This unit gives a conditional-branch compare a second meaning. It receives two source register numbers, a flag for each saying whether that operand is typed as a vector, an element count, a 3-bit compare code and the number of a destination register. If neither operand is a vector, no element loop runs. The unit pulses a request for the normal scalar branch and writes nothing.

If at least one operand is a vector, the unit steps through the elements, one per clock. For each element it reads both operands through two register-file read ports. A vector operand advances one register per element, while a scalar operand repeats the same register. The unit compares the pair and gathers the results into a bitmask, with bit i holding the outcome for element i. At the end it writes the whole mask to the destination integer register in a single write and then pulses done.

The register file is outside the block. Its read data must be valid in the same cycle as the read address.

Top module: `vec_cmp_mask`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `wr_en`, `done`, `scalar_branch` and `illegal` are all low.
- R2: A start with a legal code and both vector flags low makes `scalar_branch` high for exactly the cycle after the start edge. It causes no register write, no `done` and no `busy`.
- R3: Compare codes 3'b010 and 3'b011 are reserved. A start carrying either one makes `illegal` high for exactly the cycle after the start edge, whatever the vector flags are. It causes no write, no `scalar_branch` and no `busy`.
- R4: In the cycle that handles element i (the (i+1)-th cycle after the start edge), the read address of a vector operand is its source number plus i, modulo the register count. The read address of a scalar operand is its source number unchanged.
- R5: Compare codes are 000 equal, 001 not-equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than and 111 unsigned greater-or-equal.
- R6: Bit i of the written mask is 1 exactly when the compare of element i is true, for i below the effective length. Every bit at the effective length or above is 0.
- R7: Exactly one write occurs, for one cycle, to the destination register number given at start. It occurs in the cycle after edge VL, where the start edge counts as edge 0. A length of 0 therefore writes an all-zero mask in the cycle right after the start edge.
- R8: `done` is high for exactly one cycle, the cycle after the write.
- R9: `busy` is high from the cycle after an accepted start through the `done` cycle. A start that arrives while `busy` is high is ignored and does not change the operation in progress.
- R10: A length above the register width (XLEN) is treated as XLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to run one compare operation |
| src1_idx | input | AW | First operand register number |
| src1_vec | input | 1 | First operand is a vector |
| src2_idx | input | AW | Second operand register number |
| src2_vec | input | 1 | Second operand is a vector |
| vl | input | VLW | Element count |
| cmp_kind | input | 3 | Compare code |
| pred_idx | input | AW | Destination register for the mask |
| rd1_addr | output | AW | Read address, first operand |
| rd1_data | input | XLEN | Read data, first operand |
| rd2_addr | output | AW | Read address, second operand |
| rd2_data | input | XLEN | Read data, second operand |
| wr_en | output | 1 | Register write enable |
| wr_addr | output | AW | Register write address |
| wr_data | output | XLEN | Mask written to the register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| scalar_branch | output | 1 | One-cycle request for a normal scalar branch |
| illegal | output | 1 | One-cycle reserved-code flag |

## Verification
The assertions watch the write handshake on every cycle. They check that each write is a single cycle and is followed by `done`, that it goes to the register named at start, and that no mask bit at or above the latched length is set. They also check that `scalar_branch` and `illegal` never coincide with a write or with `busy`, and that `busy` only rises after a start.

Only the bench scenarios can show the remaining behaviour. That covers the per-element read addresses, the value of each compare under all six codes and all three vector/scalar mixes, the exact latency for lengths 0, 1, XLEN and above, and the fact that a start issued mid-operation changes nothing.

// File: rtl/vcm_pkg.sv
// Package: shared types and code helpers for the vector compare-to-mask unit.
// Assumes the compare code follows the conditional-branch ordering
// in which 010 and 011 are unused.
package vcm_pkg;

    localparam logic [2:0] CK_EQ  = 3'b000;
    localparam logic [2:0] CK_NE  = 3'b001;
    localparam logic [2:0] CK_LT  = 3'b100;
    localparam logic [2:0] CK_GE  = 3'b101;
    localparam logic [2:0] CK_LTU = 3'b110;
    localparam logic [2:0] CK_GEU = 3'b111;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } vcm_state_e;

    // A code is legal unless it is 01x.
    function automatic logic ck_legal(input logic [2:0] k);
        return k[2] | ~k[1];
    endfunction

endpackage

// File: rtl/vcm_elem_cmp.sv
// Element comparator: evaluates one compare code on one operand pair.
// Purely combinational. Bit 0 of the code inverts the base relation and
// bits 2:1 choose equality, signed less-than or unsigned less-than.
module vcm_elem_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic [2:0]   kind,
    output logic         hit
);

    logic is_eq;
    logic is_lts;
    logic is_ltu;
    logic base_rel;

    // Base relations, then select and optional inversion.
    always_comb begin
        is_eq    = (lhs == rhs);
        is_lts   = ($signed(lhs) < $signed(rhs));
        is_ltu   = (lhs < rhs);
        base_rel = kind[2] ? (kind[1] ? is_ltu : is_lts) : is_eq;
        hit      = base_rel ^ kind[0];
    end

endmodule

// File: rtl/vcm_operand_addr.sv
// Operand address generator: for a vector operand, adds the element
// step to the base register number, wrapping modulo 2**AW. For a scalar
// operand, returns the base register number unchanged.
module vcm_operand_addr #(
    parameter int AW = 5,
    parameter int IW = 5
) (
    input  logic [AW-1:0] base,
    input  logic          is_vec,
    input  logic [IW-1:0] step,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] step_w;

    // Resize the element step to the register-number width.
    generate
        if (IW == AW) begin : g_same
            assign step_w = step;
        end else if (IW > AW) begin : g_trunc
            assign step_w = step[AW-1:0];
        end else begin : g_ext
            assign step_w = {{(AW-IW){1'b0}}, step};
        end
    endgenerate

    // Pick the stepped or the fixed register number.
    always_comb begin
        addr = is_vec ? (base + step_w) : base;
    end

endmodule

// File: rtl/vcm_mask_acc.sv
// Mask accumulator: holds the predicate mask under construction.
// A clear empties it. In a compare cycle with a true result, the bit
// selected by the element index is set. Bits are only ever set, never
// cleared individually.
module vcm_mask_acc #(
    parameter int W  = 32,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          set_en,
    input  logic [IW-1:0] sel,
    input  logic          hit,
    output logic [W-1:0]  mask
);

    logic [W-1:0] set_dec;

    // One-hot decode of the bit to set in this cycle.
    generate
        for (genvar g = 0; g < W; g++) begin : g_dec
            assign set_dec[g] = set_en & hit & (sel == IW'(g));
        end
    endgenerate

    // Register the mask: reset or clear empties it, otherwise OR in new bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (clear) begin
            mask <= '0;
        end else begin
            mask <= mask | set_dec;
        end
    end

endmodule

// File: rtl/vcm_seq.sv
// Sequencer: decides what a start does (illegal code, scalar branch or
// element loop), steps the element index one per clock, then spends one
// cycle on the mask write and one on done. Starts are only seen in IDLE.
module vcm_seq #(
    parameter int VLW = 6,
    parameter int IW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           legal,
    input  logic           any_vec,
    input  logic [VLW-1:0] vl_eff,
    output logic           accept,
    output logic           running,
    output logic           wr_en,
    output logic           done,
    output logic           busy,
    output logic           br_pulse,
    output logic           ill_pulse,
    output logic [IW-1:0]  idx
);

    import vcm_pkg::*;

    vcm_state_e     state;
    logic [VLW-1:0] vl_q;
    logic           last_elem;

    // Decode the current state into control strobes.
    always_comb begin
        accept    = (state == ST_IDLE) && start && legal && any_vec;
        running   = (state == ST_RUN);
        wr_en     = (state == ST_WRITE);
        done      = (state == ST_DONE);
        busy      = (state != ST_IDLE);
        last_elem = ((VLW'(idx) + VLW'(1)) == vl_q);
    end

    // State, element index, latched length and the one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx       <= '0;
            vl_q      <= '0;
            br_pulse  <= 1'b0;
            ill_pulse <= 1'b0;
        end else begin
            br_pulse  <= 1'b0;
            ill_pulse <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (!legal) begin
                            ill_pulse <= 1'b1;
                        end else if (!any_vec) begin
                            br_pulse <= 1'b1;
                        end else begin
                            vl_q  <= vl_eff;
                            idx   <= '0;
                            state <= (vl_eff == '0) ? ST_WRITE : ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (last_elem) begin
                        state <= ST_WRITE;
                    end else begin
                        idx <= idx + IW'(1);
                    end
                end
                ST_WRITE: state <= ST_DONE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vec_cmp_mask.sv
// Top: vector compare to predicate mask.
// Latches the command on an accepted start and produces per-element
// read addresses for an external register file. Read data must return
// in the same cycle. The unit compares one element pair per clock,
// builds the mask and writes it to the destination register once.
// If neither operand is a vector, it only requests a scalar branch.
module vec_cmp_mask #(
    parameter int  XLEN = 32,
    parameter int  NREG = 32,
    localparam int AW   = $clog2(NREG),
    localparam int VLW  = $clog2(XLEN + 1),
    localparam int IW   = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   src1_idx,
    input  logic            src1_vec,
    input  logic [AW-1:0]   src2_idx,
    input  logic            src2_vec,
    input  logic [VLW-1:0]  vl,
    input  logic [2:0]      cmp_kind,
    input  logic [AW-1:0]   pred_idx,
    output logic [AW-1:0]   rd1_addr,
    input  logic [XLEN-1:0] rd1_data,
    output logic [AW-1:0]   rd2_addr,
    input  logic [XLEN-1:0] rd2_data,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [XLEN-1:0] wr_data,
    output logic            busy,
    output logic            done,
    output logic            scalar_branch,
    output logic            illegal
);

    import vcm_pkg::*;

    logic [AW-1:0]   src1_q;
    logic [AW-1:0]   src2_q;
    logic            vec1_q;
    logic            vec2_q;
    logic [2:0]      kind_q;
    logic [AW-1:0]   pred_q;
    logic [VLW-1:0]  vl_eff;
    logic            cmd_legal;
    logic            cmd_any_vec;
    logic            accept;
    logic            running;
    logic [IW-1:0]   idx;
    logic            elem_hit;
    logic [XLEN-1:0] mask;

    // Clamp the length to the register width and classify the command.
    always_comb begin
        vl_eff      = (vl > VLW'(XLEN)) ? VLW'(XLEN) : vl;
        cmd_legal   = ck_legal(cmp_kind);
        cmd_any_vec = src1_vec | src2_vec;
    end

    // Latch the operand description when an operation is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src1_q <= '0;
            src2_q <= '0;
            vec1_q <= 1'b0;
            vec2_q <= 1'b0;
            kind_q <= CK_EQ;
            pred_q <= '0;
        end else if (accept) begin
            src1_q <= src1_idx;
            src2_q <= src2_idx;
            vec1_q <= src1_vec;
            vec2_q <= src2_vec;
            kind_q <= cmp_kind;
            pred_q <= pred_idx;
        end
    end

    vcm_seq #(
        .VLW (VLW),
        .IW  (IW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .legal     (cmd_legal),
        .any_vec   (cmd_any_vec),
        .vl_eff    (vl_eff),
        .accept    (accept),
        .running   (running),
        .wr_en     (wr_en),
        .done      (done),
        .busy      (busy),
        .br_pulse  (scalar_branch),
        .ill_pulse (illegal),
        .idx       (idx)
    );

    vcm_operand_addr #(
        .AW (AW),
        .IW (IW)
    ) u_addr1 (
        .base   (src1_q),
        .is_vec (vec1_q),
        .step   (idx),
        .addr   (rd1_addr)
    );

    vcm_operand_addr #(
        .AW (AW),
        .IW (IW)
    ) u_addr2 (
        .base   (src2_q),
        .is_vec (vec2_q),
        .step   (idx),
        .addr   (rd2_addr)
    );

    vcm_elem_cmp #(
        .W (XLEN)
    ) u_cmp (
        .lhs  (rd1_data),
        .rhs  (rd2_data),
        .kind (kind_q),
        .hit  (elem_hit)
    );

    vcm_mask_acc #(
        .W  (XLEN),
        .IW (IW)
    ) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .set_en (running),
        .sel    (idx),
        .hit    (elem_hit),
        .mask   (mask)
    );

    // Write-port data and address come from the mask and the latched target.
    always_comb begin
        wr_addr = pred_q;
        wr_data = mask;
    end

endmodule

// File: rtl/vec_cmp_mask_chk.sv
// Checker for vec_cmp_mask: watches only the top-level ports, plus its
// own copy of the length and target taken at each start seen while idle.
module vec_cmp_mask_chk #(
    parameter int  XLEN = 32,
    parameter int  NREG = 32,
    localparam int AW   = $clog2(NREG),
    localparam int VLW  = $clog2(XLEN + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [VLW-1:0]  vl,
    input logic [AW-1:0]   pred_idx,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic [XLEN-1:0] wr_data,
    input logic            busy,
    input logic            done,
    input logic            scalar_branch,
    input logic            illegal
);

    logic [VLW-1:0] vl_c;
    logic [AW-1:0]  pred_c;

    // Record the length (clamped) and target of each start seen while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_c   <= '0;
            pred_c <= '0;
        end else if (start && !busy) begin
            vl_c   <= (vl > VLW'(XLEN)) ? VLW'(XLEN) : vl;
            pred_c <= pred_idx;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy && !wr_en && !done && !scalar_branch && !illegal));

    assert_branch_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scalar_branch |-> (!wr_en && !busy && !done && $past(start)));

    assert_illegal_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_en && !busy && !scalar_branch && $past(start)));

    assert_mask_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_data >> vl_c) == '0));

    assert_write_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    assert_write_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr == pred_c));

    assert_done_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> done);

    assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) && !wr_en));

    assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

bind vec_cmp_mask vec_cmp_mask_chk #(
    .XLEN (XLEN),
    .NREG (NREG)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .vl            (vl),
    .pred_idx      (pred_idx),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .busy          (busy),
    .done          (done),
    .scalar_branch (scalar_branch),
    .illegal       (illegal)
);

// File: tb/vec_cmp_mask_tb.sv
module vec_cmp_mask_tb;

    localparam int XLEN = 32;
    localparam int NREG = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  src1_idx = '0;
    logic        src1_vec = 1'b0;
    logic [4:0]  src2_idx = '0;
    logic        src2_vec = 1'b0;
    logic [5:0]  vl = '0;
    logic [2:0]  cmp_kind = '0;
    logic [4:0]  pred_idx = '0;
    logic [4:0]  rd1_addr;
    logic [31:0] rd1_data;
    logic [4:0]  rd2_addr;
    logic [31:0] rd2_data;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data;
    logic        busy;
    logic        done;
    logic        scalar_branch;
    logic        illegal;

    int vectors = 0;
    int miscompares = 0;
    int seed = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    // Register-file contents as a formula: every fourth register holds a small
    // shared value so equal pairs occur. The others are spread across both signs.
    function automatic logic [31:0] rval(input logic [4:0] a, input int s);
        if (a[1:0] == 2'b00) return 32'd7 + 32'(s);
        return (32'(a) * 32'h9E37_79B1) ^ (32'(s) * 32'h0123_4567);
    endfunction

    assign rd1_data = rval(rd1_addr, seed);
    assign rd2_data = rval(rd2_addr, seed);

    vec_cmp_mask #(.XLEN(XLEN), .NREG(NREG)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src1_idx(src1_idx), .src1_vec(src1_vec),
        .src2_idx(src2_idx), .src2_vec(src2_vec),
        .vl(vl), .cmp_kind(cmp_kind), .pred_idx(pred_idx),
        .rd1_addr(rd1_addr), .rd1_data(rd1_data),
        .rd2_addr(rd2_addr), .rd2_data(rd2_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done),
        .scalar_branch(scalar_branch), .illegal(illegal)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Expected compare outcome under the R5 encoding.
    function automatic logic ref_cmp(input logic [31:0] a, input logic [31:0] b,
                                     input logic [2:0] k);
        case (k)
            3'b000:  return a == b;
            3'b001:  return a != b;
            3'b100:  return $signed(a) < $signed(b);
            3'b101:  return $signed(a) >= $signed(b);
            3'b110:  return a < b;
            default: return a >= b;
        endcase
    endfunction

    // Run one vector operation and check addresses, mask, timing and busy.
    task automatic run_vec(input logic [4:0] s1, input logic v1, input logic [4:0] s2,
                           input logic v2, input int len, input logic [2:0] k,
                           input logic [4:0] pd, input logic inject);
        int vle;
        logic [31:0] exp_mask;
        vle = (len > XLEN) ? XLEN : len;
        exp_mask = '0;
        for (int i = 0; i < vle; i++) begin
            logic [4:0] a1;
            logic [4:0] a2;
            a1 = v1 ? 5'(s1 + 5'(i)) : s1;
            a2 = v2 ? 5'(s2 + 5'(i)) : s2;
            if (ref_cmp(rval(a1, seed), rval(a2, seed), k)) exp_mask[i] = 1'b1;
        end
        @(negedge clk);
        src1_idx = s1; src1_vec = v1; src2_idx = s2; src2_vec = v2;
        vl = 6'(len); cmp_kind = k; pred_idx = pd; start = 1'b1;
        for (int n = 1; n <= vle + 3; n++) begin
            @(negedge clk);
            start = 1'b0;
            if (inject && n == 2) begin
                // R9: a start while busy must be ignored
                start = 1'b1; pred_idx = 5'(pd + 5'd1); vl = 6'd1;
                src1_idx = 5'd2; cmp_kind = 3'b001;
            end
            if (n <= vle) begin
                check(rd1_addr == (v1 ? 5'(s1 + 5'(n - 1)) : s1), "R4 rd1_addr",
                      32'(rd1_addr), 32'(v1 ? 5'(s1 + 5'(n - 1)) : s1));
                check(rd2_addr == (v2 ? 5'(s2 + 5'(n - 1)) : s2), "R4 rd2_addr",
                      32'(rd2_addr), 32'(v2 ? 5'(s2 + 5'(n - 1)) : s2));
            end
            check(wr_en == (n == vle + 1), "R7 wr_en timing", 32'(wr_en), 32'(n == vle + 1));
            if (wr_en) begin
                check(wr_addr == pd, "R7 wr_addr", 32'(wr_addr), 32'(pd));
                check(wr_data == exp_mask, "R5 R6 R10 mask", wr_data, exp_mask);
            end
            check(done == (n == vle + 2), "R8 done timing", 32'(done), 32'(n == vle + 2));
            check(busy == (n <= vle + 2), "R9 busy", 32'(busy), 32'(n <= vle + 2));
            check(!scalar_branch && !illegal, "R2 R3 no side pulse",
                  32'({scalar_branch, illegal}), 32'd0);
            if (inject && n == 3) start = 1'b0;
        end
        start = 1'b0;
    endtask

    // Run a start that must not loop: either a scalar branch or an illegal code.
    task automatic run_short(input logic v1, input logic v2, input logic [2:0] k,
                             input logic exp_br, input logic exp_ill, input string tag);
        @(negedge clk);
        src1_idx = 5'd4; src1_vec = v1; src2_idx = 5'd9; src2_vec = v2;
        vl = 6'd5; cmp_kind = k; pred_idx = 5'd12; start = 1'b1;
        for (int n = 1; n <= 3; n++) begin
            @(negedge clk);
            start = 1'b0;
            check(scalar_branch == (exp_br && n == 1), {tag, " scalar_branch"},
                  32'(scalar_branch), 32'(exp_br && n == 1));
            check(illegal == (exp_ill && n == 1), {tag, " illegal"},
                  32'(illegal), 32'(exp_ill && n == 1));
            check(!wr_en && !busy && !done, {tag, " no write/busy/done"},
                  32'({wr_en, busy, done}), 32'd0);
        end
    endtask

    initial begin
        logic [2:0] kinds [6];
        int lens [6];
        logic [4:0] p1 [4];
        logic [4:0] p2 [4];
        kinds = '{3'b000, 3'b001, 3'b100, 3'b101, 3'b110, 3'b111};
        lens  = '{0, 1, 3, 7, 32, 40};
        p1    = '{5'd0, 5'd5, 5'd3, 5'd30};
        p2    = '{5'd4, 5'd17, 5'd3, 5'd9};

        repeat (3) @(negedge clk);
        check(!busy && !wr_en && !done && !scalar_branch && !illegal, "R1 in reset",
              32'({busy, wr_en, done, scalar_branch, illegal}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !wr_en && !done && !scalar_branch && !illegal, "R1 after reset",
              32'({busy, wr_en, done, scalar_branch, illegal}), 32'd0);

        // R2: both scalar, all legal codes
        for (int k = 0; k < 6; k++) run_short(1'b0, 1'b0, kinds[k], 1'b1, 1'b0, "R2");
        // R3: reserved codes, scalar and vector
        run_short(1'b0, 1'b0, 3'b010, 1'b0, 1'b1, "R3");
        run_short(1'b1, 1'b0, 3'b011, 1'b0, 1'b1, "R3");
        run_short(1'b1, 1'b1, 3'b010, 1'b0, 1'b1, "R3");

        // R4..R8, R10 sweep over codes, vector mixes, lengths and register pairs
        for (int s = 0; s < 2; s++) begin
            seed = s;
            for (int k = 0; k < 6; k++)
                for (int m = 1; m < 4; m++)
                    for (int l = 0; l < 6; l++)
                        for (int p = 0; p < 4; p++)
                            run_vec(p1[p], m[0], p2[p], m[1], lens[l], kinds[k],
                                    5'(p * 7 + l), 1'b0);
        end

        // R9: start while busy is ignored
        run_vec(5'd1, 1'b1, 5'd8, 1'b0, 6, 3'b100, 5'd20, 1'b1);
        run_vec(5'd28, 1'b1, 5'd2, 1'b1, 32, 3'b111, 5'd31, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog R9: actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule